// File: doc/BRIEF.md
# CCD Multi-Phase Clock Sequencer

This block produces the logic-level phase clocks for a charge-coupled analog delay line that samples a waveform. The delay line is laid out serial-in, parallel through, serial-out. A short serial input row (A) fills one sample per fast tick. Every eighth sample, the row is dumped into a parallel array (B) through a transfer-in pulse. Rows leave the array into a serial output register (C), which is read out at a constant slow rate. A reset clock empties the output wells between readout samples.

The sequencer has two modes of operation.

- **Fast-in / slow-out.** This mode is armed by software. It is then triggered, and after a programmed number of post-trigger samples it switches to a timed readout of fixed length. At the end of the readout it raises a one-cycle done flag and goes back to filling.
- **Short-pipe.** This mode is selected by a level input. The whole line then runs continuously at the slow rate, with the transfer-in clock toggling on every cycle.

The sample tick period and the mode choice come from an outside timebase. The slow rate is the system clock divided by `2*HALF_DIV`. A 100 MHz clock with `HALF_DIV` = 100 gives 500 kHz.

Top module: `ccdPhaseSeq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the A, B and transfer-in outputs are low. `clkReset`, `readout` and `done` are also low. Both C outputs are high.
- R2: In fill (not readout, not short-pipe), each `sampleTick` seen at a clock edge gives `clkA1` high for exactly the following cycle. The cycle after that, `clkA2` is high, except on the tick whose slot is 7: there `clkA2` stays low and `xferIn` pulses for that one cycle instead. The slot counts ticks modulo 8 from reset, starting at 0.
- R3: During fill, a slot-7 tick is followed by `clkB1` high in the third cycle after its edge and `clkB2` high in the fourth. B therefore pulses once per eight A cycles.
- R4: During fill, `clkC1` and `clkC2` are both held high.
- R5: After `arm`, a `trig` starts the post-trigger count. Only ticks at later edges count. Readout begins at the first tick whose count is at least `postCount` and whose slot is 7, so the last row is always whole. `readout` rises in the cycle after that tick's edge, together with its `clkA1` pulse.
- R6: In readout, `clkC1` is high for `HALF_DIV` cycles and then low for `HALF_DIV` cycles, starting high in the first readout cycle. `clkC2` is its inverse, and `clkReset` follows `clkC1`.
- R7: In readout, `clkB1` pulses for one cycle at the start of each C cycle whose index modulo 8 is 7, and `clkB2` pulses in the next cycle. C cycles are counted from 0 at readout start.
- R8: After `READ_LEN` C cycles, `readout` falls and `done` is high for exactly one cycle. The C outputs return high. A `trig` that arrives without a preceding `arm` has no effect.
- R9: While `pipeMode` is high, `clkC1` runs at the slow rate, and `xferIn` and `clkB1` equal `clkC1` while `clkB2` equals `clkC2`. The A outputs stay low, and `sampleTick` and `trig` have no effect. The fill slot is unchanged when short-pipe mode ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleTick | input | 1 | One-cycle fast sample strobe, at least 5 cycles apart |
| pipeMode | input | 1 | High selects short-pipe operation |
| arm | input | 1 | Arms the acquisition for the next trigger |
| trig | input | 1 | Trigger event |
| postCount | input | CNT_W | Samples to take after the trigger before readout |
| clkA1 | output | 1 | Serial row phase 1 |
| clkA2 | output | 1 | Serial row phase 2 |
| xferIn | output | 1 | Transfer-in pulse into the parallel array |
| clkB1 | output | 1 | Parallel array phase 1 |
| clkB2 | output | 1 | Parallel array phase 2 |
| clkC1 | output | 1 | Output register phase 1 |
| clkC2 | output | 1 | Output register phase 2 |
| clkReset | output | 1 | Output well reset clock |
| readout | output | 1 | High during slow readout |
| done | output | 1 | One-cycle pulse at the end of readout |

## Verification
Each fill tick has a fixed result timeline, counted from the edge that samples the tick: A1 one cycle later, A2 or transfer-in two cycles later, and the B pair three and four cycles later. The bench samples each of these at the falling edge of the matching cycle. Readout results are indexed by the cycle number counted from the first readout cycle, and every expected value follows arithmetically from the index, the divider half-period and the row length. The `done` pulse is expected at index `READ_LEN*2*HALF_DIV`. Short-pipe mode runs at an arbitrary phase, so it is checked through relations between outputs and through values one half-period and one full period apart.

// File: rtl/ccdSeqPkg.sv
package ccdSeqPkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2,
    ST_READ  = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic aGo;     // start an A pulse train this edge
    logic aLast;   // that sample closes a row
    logic inRead;  // slow readout active
    logic pipe;    // short-pipe override
  } seqStrobe_t;

endpackage

// File: rtl/ccdSeqCtrl.sv
module ccdSeqCtrl
  import ccdSeqPkg::*;
#(
  parameter int ROW_LEN = 8,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleTick,
  input  logic             pipeMode,
  input  logic             arm,
  input  logic             trig,
  input  logic [CNT_W-1:0] postCount,
  input  logic             readEnd,
  output seqStrobe_t       strobe,
  output logic             readout,
  output logic             done
);

  localparam int SLOT_W = (ROW_LEN > 1) ? $clog2(ROW_LEN) : 1;

  seqState_t         state;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  postCnt;
  logic [CNT_W:0]    postNext;
  logic              tickEn;
  logic              lastSlot;

  assign tickEn   = sampleTick && !pipeMode && (state != ST_READ);
  assign lastSlot = (slot == SLOT_W'(ROW_LEN - 1));
  assign postNext = {1'b0, postCnt} + 1'b1;
  assign readout  = (state == ST_READ);

  always_comb begin
    strobe.aGo    = tickEn;
    strobe.aLast  = lastSlot;
    strobe.inRead = readout;
    strobe.pipe   = pipeMode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_WAIT;
      slot    <= '0;
      postCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tickEn) slot <= lastSlot ? '0 : slot + 1'b1;
      case (state)
        ST_WAIT:  if (arm && !pipeMode) state <= ST_ARMED;
        ST_ARMED: if (trig && !pipeMode) begin
          state   <= ST_POST;
          postCnt <= '0;
        end
        ST_POST: if (tickEn) begin
          if (postNext >= {1'b0, postCount} && lastSlot) state <= ST_READ;
          else if (postCnt != '1) postCnt <= postCnt + 1'b1;
        end
        ST_READ: if (readEnd) begin
          state <= ST_WAIT;
          done  <= 1'b1;
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/ccdSeqPath.sv
module ccdSeqPath
  import ccdSeqPkg::*;
#(
  parameter int HALF_DIV = 100,
  parameter int READ_LEN = 32,
  parameter int ROW_LEN  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strobe,
  output logic       readEnd,
  output logic       clkA1,
  output logic       clkA2,
  output logic       xferIn,
  output logic       clkB1,
  output logic       clkB2,
  output logic       clkC1,
  output logic       clkC2,
  output logic       clkReset
);

  localparam int DIV    = 2 * HALF_DIV;
  localparam int DIV_W  = $clog2(DIV);
  localparam int CYC_W  = (READ_LEN > 1) ? $clog2(READ_LEN) : 1;
  localparam int STAGES = 4;

  logic [STAGES-1:0] goPipe;
  logic [STAGES-1:0] lastPipe;
  logic [DIV_W-1:0]  divCnt;
  logic [CYC_W-1:0]  cycIdx;
  logic              divRun;
  logic              cHi;
  logic              rowEdge;

  // fill pulse train: one stage per output slot
  always_ff @(posedge clk) begin
    if (rst) begin
      goPipe   <= '0;
      lastPipe <= '0;
    end else begin
      goPipe   <= {goPipe[STAGES-2:0], strobe.aGo};
      lastPipe <= {lastPipe[STAGES-2:0], strobe.aGo && strobe.aLast};
    end
  end

  // slow-rate divider and C-cycle index
  assign divRun = strobe.inRead || strobe.pipe;

  always_ff @(posedge clk) begin
    if (rst || !divRun) begin
      divCnt <= '0;
      cycIdx <= '0;
    end else if (divCnt == DIV_W'(DIV - 1)) begin
      divCnt <= '0;
      cycIdx <= (cycIdx == CYC_W'(READ_LEN - 1)) ? '0 : cycIdx + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign cHi     = (divCnt < DIV_W'(HALF_DIV));
  assign rowEdge = strobe.inRead && ((32'(cycIdx) % ROW_LEN) == ROW_LEN - 1);
  assign readEnd = strobe.inRead && (divCnt == DIV_W'(DIV - 1))
                   && (cycIdx == CYC_W'(READ_LEN - 1));

  always_comb begin
    clkA1    = goPipe[0] && !strobe.pipe;
    clkA2    = goPipe[1] && !lastPipe[1] && !strobe.pipe;
    clkC1    = divRun ? cHi : 1'b1;
    clkC2    = divRun ? !cHi : 1'b1;
    clkReset = divRun && cHi;
    if (strobe.pipe) begin
      xferIn = cHi;
      clkB1  = cHi;
      clkB2  = !cHi;
    end else begin
      xferIn = lastPipe[1];
      clkB1  = lastPipe[2] || (rowEdge && divCnt == DIV_W'(0));
      clkB2  = lastPipe[3] || (rowEdge && divCnt == DIV_W'(1));
    end
  end

endmodule

// File: rtl/ccdPhaseSeq.sv
module ccdPhaseSeq
  import ccdSeqPkg::*;
#(
  parameter int HALF_DIV = 100,
  parameter int READ_LEN = 32,
  parameter int ROW_LEN  = 8,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleTick,
  input  logic             pipeMode,
  input  logic             arm,
  input  logic             trig,
  input  logic [CNT_W-1:0] postCount,
  output logic             clkA1,
  output logic             clkA2,
  output logic             xferIn,
  output logic             clkB1,
  output logic             clkB2,
  output logic             clkC1,
  output logic             clkC2,
  output logic             clkReset,
  output logic             readout,
  output logic             done
);

  seqStrobe_t strobe;
  logic       readEnd;

  ccdSeqCtrl #(.ROW_LEN(ROW_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .sampleTick(sampleTick), .pipeMode(pipeMode),
    .arm(arm), .trig(trig), .postCount(postCount), .readEnd(readEnd),
    .strobe(strobe), .readout(readout), .done(done)
  );

  ccdSeqPath #(.HALF_DIV(HALF_DIV), .READ_LEN(READ_LEN), .ROW_LEN(ROW_LEN)) u_path (
    .clk(clk), .rst(rst), .strobe(strobe), .readEnd(readEnd),
    .clkA1(clkA1), .clkA2(clkA2), .xferIn(xferIn), .clkB1(clkB1),
    .clkB2(clkB2), .clkC1(clkC1), .clkC2(clkC2), .clkReset(clkReset)
  );

endmodule

// File: rtl/ccdPhaseSeqChk.sv
module ccdPhaseSeqChk (
  input logic clk,
  input logic rst,
  input logic pipeMode,
  input logic clkA1,
  input logic xferIn,
  input logic clkB1,
  input logic clkC1,
  input logic clkC2,
  input logic readout,
  input logic done
);

  assert_xfer_after_a1_R2: assert property (@(posedge clk) disable iff (rst)
    (!pipeMode && !$past(pipeMode) && xferIn) |-> $past(clkA1));

  assert_b_after_xfer_R3: assert property (@(posedge clk) disable iff (rst)
    (!pipeMode && xferIn) |=> (pipeMode || clkB1));

  assert_c_high_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (!readout && !pipeMode) |-> (clkC1 && clkC2));

  assert_entry_on_row_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(readout) |-> clkA1);

  assert_c_pair_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (readout && $past(readout) && (clkC1 != $past(clkC1))) |-> (clkC2 != $past(clkC2)));

  assert_done_ends_read_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(readout) && !readout));

endmodule

bind ccdPhaseSeq ccdPhaseSeqChk u_chk (
  .clk(clk), .rst(rst), .pipeMode(pipeMode), .clkA1(clkA1), .xferIn(xferIn),
  .clkB1(clkB1), .clkC1(clkC1), .clkC2(clkC2), .readout(readout), .done(done)
);

// File: tb/sim_ccdPhaseSeq.sv
module sim_ccdPhaseSeq;

  localparam int HALF = 4;
  localparam int DIV  = 2 * HALF;
  localparam int RLEN = 16;
  localparam int ROW  = 8;
  localparam int CW   = 8;
  localparam int RCYC = RLEN * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleTick = 1'b0, pipeMode = 1'b0, arm = 1'b0, trig = 1'b0;
  logic [CW-1:0] postCount = '0;
  logic clkA1, clkA2, xferIn, clkB1, clkB2, clkC1, clkC2, clkReset, readout, done;

  int nChecks = 0;
  int nErr    = 0;
  int slotB   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ccdPhaseSeq #(.HALF_DIV(HALF), .READ_LEN(RLEN), .ROW_LEN(ROW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .sampleTick(sampleTick), .pipeMode(pipeMode),
    .arm(arm), .trig(trig), .postCount(postCount),
    .clkA1(clkA1), .clkA2(clkA2), .xferIn(xferIn), .clkB1(clkB1), .clkB2(clkB2),
    .clkC1(clkC1), .clkC2(clkC2), .clkReset(clkReset), .readout(readout), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one fill tick; expSw: readout expected to start at this tick
  task automatic doTick(input bit expSw);
    bit last = (slotB == ROW - 1);
    @(negedge clk) sampleTick = 1'b1;
    @(negedge clk) sampleTick = 1'b0;
    chk("R2 a1", int'(clkA1), 1);
    chk("R2 a2 early", int'(clkA2), 0);
    chk("R4 c1 high", int'(clkC1), 1);
    chk("R4/R6 c2", int'(clkC2), int'(!expSw));
    chk("R5 readout", int'(readout), int'(expSw));
    @(negedge clk);
    chk("R2 a1 off", int'(clkA1), 0);
    chk("R2 a2", int'(clkA2), int'(!last));
    chk("R2 xferIn", int'(xferIn), int'(last));
    @(negedge clk);
    chk("R3 b1", int'(clkB1), int'(last));
    @(negedge clk);
    chk("R3 b2", int'(clkB2), int'(last));
    slotB = (slotB + 1) % ROW;
  endtask

  task automatic runAcq(input int pc);
    int n = 0;
    bit sw = 1'b0;
    postCount = CW'(pc);
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0; trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    while (!sw) begin
      n++;
      sw = (n >= pc) && (slotB == ROW - 1);
      doTick(sw);
    end
    for (int j = 4; j < RCYC; j++) begin
      bit hi;
      @(negedge clk);
      hi = ((j % DIV) < HALF);
      chk("R6 c1", int'(clkC1), int'(hi));
      chk("R6 c2", int'(clkC2), int'(!hi));
      chk("R6 reset clk", int'(clkReset), int'(hi));
      chk("R7 b1", int'(clkB1), int'((j % DIV == 0) && ((j / DIV) % ROW == ROW - 1)));
      chk("R7 b2", int'(clkB2), int'((j % DIV == 1) && ((j / DIV) % ROW == ROW - 1)));
      if (j == RCYC - 1) chk("R8 still reading", int'(readout), 1);
    end
    @(negedge clk);
    chk("R8 done", int'(done), 1);
    chk("R8 readout off", int'(readout), 0);
    chk("R8 c1 high", int'(clkC1), 1);
    chk("R8 c2 high", int'(clkC2), 1);
    @(negedge clk);
    chk("R8 done single", int'(done), 0);
  endtask

  initial begin
    int hist[5*DIV];
    int hiCnt;
    repeat (3) @(negedge clk);
    chk("R1 a1", int'(clkA1), 0);
    chk("R1 xferIn", int'(xferIn), 0);
    chk("R1 c1", int'(clkC1), 1);
    chk("R1 c2", int'(clkC2), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 a2", int'(clkA2), 0);
    chk("R1 b1", int'(clkB1), 0);
    chk("R1 b2", int'(clkB2), 0);
    chk("R1 reset clk", int'(clkReset), 0);
    chk("R1 readout", int'(readout), 0);
    chk("R1 done", int'(done), 0);

    // trigger without arm must not start anything (R8)
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    for (int k = 0; k < 2 * ROW; k++) doTick(1'b0);

    // post-trigger sweep
    runAcq(0);
    runAcq(5);
    runAcq(9);
    runAcq(16);

    // short-pipe mode R9
    @(negedge clk) pipeMode = 1'b1;
    hiCnt = 0;
    for (int k = 0; k < 5 * DIV; k++) begin
      @(negedge clk);
      sampleTick = (k % 5 == 0);
      trig = (k == 7);
      arm  = (k == 3);
      hist[k] = int'(clkC1);
      hiCnt += int'(clkC1);
      chk("R9 xferIn", int'(xferIn), int'(clkC1));
      chk("R9 b1", int'(clkB1), int'(clkC1));
      chk("R9 b2", int'(clkB2), int'(clkC2));
      chk("R9 c2", int'(clkC2), int'(!clkC1));
      chk("R9 a1", int'(clkA1), 0);
      chk("R9 a2", int'(clkA2), 0);
      chk("R9 readout", int'(readout), 0);
      if (k >= DIV) chk("R9 period", hist[k], hist[k-DIV]);
      if (k >= HALF) chk("R9 half", hist[k], 1 - hist[k-HALF]);
    end
    sampleTick = 1'b0; trig = 1'b0; arm = 1'b0;
    chk("R9 duty", hiCnt, 5 * HALF);
    @(negedge clk) pipeMode = 1'b0;
    @(negedge clk);
    chk("R9 c back high", int'(clkC1 && clkC2), 1);
    for (int k = 0; k < ROW; k++) doTick(1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule